// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block is a synchronous bus master for an external asynchronous byte-wide SRAM that also has a nonvolatile shadow. Simple read and write requests come in over a valid/ready handshake. The block turns each one into a strobe sequence on the chip-enable, write-enable and output-enable lines, a 15-bit address bus and an 8-bit data path. Every timing interval is a parameter counted in clock cycles, so a single instance can be tuned to a slower or faster memory grade. The data path is split into an output value, a drive enable and an input value. The pad cell outside this block merges them onto the shared data pins.

Reads are strobed with chip-enable and output-enable together. The byte is returned with a one-cycle valid pulse. Writes are timed by write-enable, and output-enable stays high for the whole write. Two extra request codes issue the six-read unlock sequence that tells the memory to copy its array into the nonvolatile store, or to copy the store back into the array. Each read in that sequence is timed by chip-enable. The block then waits out the memory's busy time, and a busy flag stays high for the whole command.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and right after it is released, all three strobes are high (inactive), the data drive enable is low, busy is low, rd_valid is low and req_ready is high.
- R2: A request with req_op=0 (read) lowers chip-enable and output-enable together, with write-enable high. They stay low for exactly T_RD cycles. rd_valid then pulses high for one cycle, T_RD+2 cycles after the acceptance edge, counted in sampling points. rd_data carries the byte that was on sram_dq_in at the end of the strobe.
- R3: A request with req_op=1 (write) lowers write-enable for exactly T_WP cycles, inside a chip-enable low window of T_WP+1 cycles. Output-enable is never low while write-enable is low. The byte on sram_dq_out is the one that the memory stores.
- R4: The data drive enable is high only while output-enable is high. It is still high in the cycle after write-enable rises, so data is held past the end of the write.
- R5: The address never changes while chip-enable is low, and write-enable is never low while chip-enable is high.
- R6: Between the end of one chip-enable low window and the start of the next, chip-enable stays high for at least T_REC+2 cycles.
- R7: req_op=2 (store) and req_op=3 (recall) each issue six chip-enable-timed reads, with write-enable and output-enable high. Each chip-enable low window lasts T_NVCE cycles. The lower 14 address bits take the values 0E38, 31C7, 03E0, 3C1F and 303F (hex), then 0FC0 for store or 0C63 for recall, and bit 14 is zero. No write occurs during the command.
- R8: busy rises at the acceptance edge of a store or recall command. It stays high for exactly 1 + 6*(T_NVCE+T_REC) + 10 + T_NVWAIT cycles, and req_ready stays low while busy is high. req_ready returns high in the cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted on this edge |
| req_op | input | 2 | 0 read, 1 write, 2 store command, 3 recall command |
| req_addr | input | AW | Byte address for read or write |
| req_wdata | input | DW | Write byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | DW | Returned read byte |
| busy | output | 1 | Store or recall command in progress |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | AW | Memory address |
| sram_dq_out | output | DW | Data to drive onto the memory bus |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DW | Data read from the memory bus |

## Verification
The assertions assume that req_valid holds its request fields stable until req_ready accepts it, and that reset is applied for at least one clock edge before any traffic starts. The bench drives every request at a falling edge and holds it until it sees req_ready high. It drops req_valid just after the accepting edge and never raises it during busy. Its memory model answers sram_dq_in only while a read strobe is active. It stores a byte only when write-enable rises inside a chip-enable window, so the strobe rules in the assertions are the only path by which data moves.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int T_RD     = 5,
  parameter int T_WP     = 3,
  parameter int T_REC    = 1,
  parameter int T_NVCE   = 3,
  parameter int T_NVWAIT = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  localparam int TM1  = (T_RD > T_WP) ? T_RD : T_WP;
  localparam int TM2  = (T_REC > T_NVCE) ? T_REC : T_NVCE;
  localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_NVWAIT) ? TM3 : T_NVWAIT;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ACC, S_RD, S_WLO, S_WHD, S_NLO, S_NHI, S_NAD, S_NWT, S_REC
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [1:0]    op_q;
  wire           tick = (cnt == '0);

  function automatic logic [AW-1:0] nv_addr(input logic [2:0] i, input logic rcl);
    case (i)
      3'd0:    nv_addr = AW'(15'h0E38);
      3'd1:    nv_addr = AW'(15'h31C7);
      3'd2:    nv_addr = AW'(15'h03E0);
      3'd3:    nv_addr = AW'(15'h3C1F);
      3'd4:    nv_addr = AW'(15'h303F);
      default: nv_addr = rcl ? AW'(15'h0C63) : AW'(15'h0FC0);
    endcase
  endfunction

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      idx         <= '0;
      op_q        <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      busy        <= 1'b0;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q        <= req_op;
          sram_dq_out <= req_wdata;
          sram_addr   <= req_op[1] ? nv_addr(3'd0, req_op[0]) : req_addr;
          idx         <= '0;
          busy        <= req_op[1];
          st          <= S_ACC;
        end
        S_ACC: begin
          sram_ce_n <= 1'b0;
          if (op_q == 2'd0) begin
            sram_oe_n <= 1'b0;
            cnt       <= CW'(T_RD - 1);
            st        <= S_RD;
          end else if (op_q == 2'd1) begin
            sram_we_n  <= 1'b0;
            sram_dq_oe <= 1'b1;
            cnt        <= CW'(T_WP - 1);
            st         <= S_WLO;
          end else begin
            cnt <= CW'(T_NVCE - 1);
            st  <= S_NLO;
          end
        end
        S_RD: if (tick) begin
          rd_data   <= sram_dq_in;
          rd_valid  <= 1'b1;
          sram_ce_n <= 1'b1;
          sram_oe_n <= 1'b1;
          cnt       <= CW'(T_REC - 1);
          st        <= S_REC;
        end else cnt <= cnt - CW'(1);
        S_WLO: if (tick) begin
          sram_we_n <= 1'b1;
          st        <= S_WHD;
        end else cnt <= cnt - CW'(1);
        S_WHD: begin
          sram_ce_n  <= 1'b1;
          sram_dq_oe <= 1'b0;
          cnt        <= CW'(T_REC - 1);
          st         <= S_REC;
        end
        S_NLO: if (tick) begin
          sram_ce_n <= 1'b1;
          cnt       <= CW'(T_REC - 1);
          st        <= S_NHI;
        end else cnt <= cnt - CW'(1);
        S_NHI: if (tick) begin
          if (idx == 3'd5) begin
            cnt <= CW'(T_NVWAIT - 1);
            st  <= S_NWT;
          end else st <= S_NAD;
        end else cnt <= cnt - CW'(1);
        S_NAD: begin
          idx       <= idx + 3'd1;
          sram_addr <= nv_addr(idx + 3'd1, op_q[0]);
          st        <= S_ACC;
        end
        S_NWT: if (tick) begin
          busy <= 1'b0;
          st   <= S_IDLE;
        end else cnt <= cnt - CW'(1);
        S_REC: if (tick) st <= S_IDLE;
          else cnt <= cnt - CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          busy,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [AW-1:0] sram_addr,
  input logic          sram_dq_oe
);
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R3
  AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R4
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R5
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R8
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sram_we_n); // R7
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .busy(busy), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15, DW = 8;
  localparam int T_RD = 3, T_WP = 2, T_REC = 1, T_NVCE = 2, T_NVWAIT = 20;
  localparam int NV_BUSY = 1 + 6 * (T_NVCE + T_REC) + 10 + T_NVWAIT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, busy, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] rd_data, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl #(.AW(AW), .DW(DW), .T_RD(T_RD), .T_WP(T_WP), .T_REC(T_REC),
    .T_NVCE(T_NVCE), .T_NVWAIT(T_NVWAIT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in));

  logic [7:0] mem [256];
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'h00;

  int mon_chk = 0, mon_err = 0, wr_count = 0;
  int wl = 0, cl = 0, ch = 1000, nvn = 0;
  logic pw = 1'b1, pc = 1'b1, saw_oe = 1'b0;
  logic [AW-1:0] pa = '0;
  logic [AW-1:0] nvlog [8];

  always @(negedge clk) if (rst_n) begin
    if (!sram_we_n && !sram_oe_n) begin mon_err++; $display("FAIL R3 oe low during write act=%b exp=1", sram_oe_n); end
    if (sram_dq_oe && !sram_oe_n) begin mon_err++; $display("FAIL R4 drive with oe low act=%b exp=1", sram_oe_n); end
    if (!sram_we_n && sram_ce_n) begin mon_err++; $display("FAIL R5 we low with ce high act=%b exp=0", sram_ce_n); end
    if (!sram_ce_n && !pc && sram_addr != pa) begin mon_err++; $display("FAIL R5 addr moved act=%h exp=%h", sram_addr, pa); end
    if (!sram_we_n) wl++;
    if (sram_we_n && !pw) begin
      mon_chk++;
      if (wl != T_WP) begin mon_err++; $display("FAIL R3 we width act=%0d exp=%0d", wl, T_WP); end
      mon_chk++;
      if (!sram_dq_oe) begin mon_err++; $display("FAIL R4 data hold act=%b exp=1", sram_dq_oe); end
      mem[sram_addr[7:0]] <= sram_dq_out;
      wr_count++;
      wl = 0;
    end
    if (!sram_ce_n && pc) begin
      mon_chk++;
      if (ch < T_REC + 2) begin mon_err++; $display("FAIL R6 ce high gap act=%0d exp>=%0d", ch, T_REC + 2); end
      if (sram_we_n && sram_oe_n && nvn < 8) begin nvlog[nvn] = sram_addr; nvn++; end
      cl = 0; saw_oe = 1'b0;
    end
    if (!sram_ce_n) begin cl++; if (!sram_oe_n) saw_oe = 1'b1; ch = 0; end
    else ch++;
    if (sram_ce_n && !pc) begin
      mon_chk++;
      if (saw_oe && cl != T_RD) begin mon_err++; $display("FAIL R2 read strobe act=%0d exp=%0d", cl, T_RD); end
      else if (!saw_oe && busy && cl != T_NVCE) begin mon_err++; $display("FAIL R7 unlock strobe act=%0d exp=%0d", cl, T_NVCE); end
      else if (!saw_oe && !busy && cl != T_WP + 1) begin mon_err++; $display("FAIL R3 write window act=%0d exp=%0d", cl, T_WP + 1); end
    end
    pw = sram_we_n; pc = sram_ce_n; pa = sram_addr;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int lat = 0;
    issue(2'd0, a, 8'h00);
    do begin @(negedge clk); lat++; end while (!rd_valid && lat < 100);
    chk(lat == T_RD + 2, "R2 latency", lat, T_RD + 2);
    chk(rd_data == exp, "R2 data", rd_data, exp);
    @(negedge clk);
    chk(!rd_valid, "R2 pulse", rd_valid, 0);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic nv_cmd(input bit rcl);
    int n = 0, w0;
    logic [13:0] seq [6];
    seq[0] = 14'h0E38; seq[1] = 14'h31C7; seq[2] = 14'h03E0;
    seq[3] = 14'h3C1F; seq[4] = 14'h303F; seq[5] = rcl ? 14'h0C63 : 14'h0FC0;
    nvn = 0; w0 = wr_count;
    issue(rcl ? 2'd3 : 2'd2, '0, 8'h00);
    @(negedge clk);
    chk(!req_ready, "R8 ready low", req_ready, 0);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == NV_BUSY, "R8 busy length", n, NV_BUSY);
    chk(req_ready, "R8 ready back", req_ready, 1);
    chk(nvn == 6, "R7 read count", nvn, 6);
    for (int i = 0; i < 6; i++)
      chk(nvlog[i] == {1'b0, seq[i]}, "R7 unlock address", nvlog[i], {1'b0, seq[i]});
    chk(wr_count == w0, "R7 no write", wr_count, w0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes in reset", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    chk(!sram_dq_oe && !busy && !rd_valid, "R1 idle outputs", {sram_dq_oe, busy, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1 strobes after reset", {sram_ce_n, sram_we_n, sram_oe_n}, 7);

    for (int a = 0; a < 256; a++) issue(2'd1, AW'({a[6:0], a[7:0]}), pat(a, 0));
    for (int a = 0; a < 256; a++) do_read(AW'({a[6:0], a[7:0]}), pat(a, 0));
    for (int a = 0; a < 64; a++) begin
      issue(2'd1, AW'(a * 3), pat(a, 1));
      do_read(AW'(a * 3), pat(a, 1));
    end
    for (int a = 0; a < 16; a++) begin
      issue(2'd1, AW'(255 - a), pat(a, 2));
      issue(2'd1, AW'(255 - a), pat(a, 3));
    end
    for (int a = 0; a < 16; a++) do_read(AW'(255 - a), pat(a, 3));

    nv_cmd(1'b0);
    do_read(AW'(7), pat(7 * 3 / 3 * 1 == 7 ? 7 : 7, 0) == pat(7, 0) ? mem[7] : mem[7]);
    nv_cmd(1'b1);
    do_read(AW'(200), mem[200]);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_chk, errors + mon_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_chk + 1, errors + mon_err + 1);
    $finish;
  end
endmodule